// File: doc/BRIEF.md
# Remote-Control Carrier Generator

This block turns a clock enable that pulses once per instruction cycle (one in every four system clocks) into a carrier waveform for an infrared remote-control transmitter. A static configuration sets the division ratio as a factor of two or three times a power of two (exponent 0 to 3). Where the ratio allows it, a duty select picks a high time of one half or one third of the period. Software drives a one-bit output latch through a small write port. In carrier mode the latch acts as an active-low gate: writing 0 starts the carrier and writing 1 stops it, with the pin held low. In level mode the pin simply follows the latch.

The period counter sits at zero while the carrier is gated off. Each gate-on therefore begins with a complete high phase. The latch reads back as a byte with only the low bit in use.

Top module: `ir_carrier_gen`

## Requirements
- R1: In carrier mode with the gate open, the pin waveform repeats every m×2^n instruction ticks, where m is 2 when `ratio_m3_i`=0 and 3 when it is 1, and n is `ratio_exp_i` (0..3).
- R2: With m=2 (ratios 2, 4, 8, 16) the pin is high for exactly half of each period, whatever `duty_third_i` says.
- R3: With ratio 3 (m=3, n=0) the pin is high for one tick of every three, even when `duty_third_i`=0 asks for one half.
- R4: With ratios 6, 12 and 24, `duty_third_i`=1 gives a high time of one third of the period and `duty_third_i`=0 gives one half.
- R5: Each period starts with its high phase: the pin is high for the first H ticks of the period and low for the rest.
- R6: In carrier mode (`carrier_mode_i`=1) a latch value of 0 lets the carrier through and a latch value of 1 holds the pin low.
- R7: In level mode (`carrier_mode_i`=0) the pin equals the latch value and no carrier appears.
- R8: After reset the latch holds 1, the readback is 8'h01, and in carrier mode the pin is low.
- R9: The readback is `{7'b0, latch}`. Bits 7..1 of a written byte have no effect on the readback or the pin.
- R10: The period counter restarts when the gate opens, so the pin is high from the clock edge that stores the 0. The first period is complete.
- R11: The carrier advances only on clock edges where `tick_i` is 1. Without ticks the pin holds its value.
- R12: A write (`wr_en_i`=1) takes effect at the rising edge that samples it. The readback and the pin show the new latch value right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Instruction-rate clock enable (one cycle in four) |
| carrier_mode_i | input | 1 | 1 selects carrier output, 0 selects level output |
| ratio_m3_i | input | 1 | Ratio factor: 0 gives 2, 1 gives 3 |
| ratio_exp_i | input | 2 | Power-of-two exponent n of the ratio |
| duty_third_i | input | 1 | 1 requests one-third duty where the ratio allows it |
| wr_en_i | input | 1 | Latch write strobe |
| wr_data_i | input | 8 | Write data; only bit 0 is stored |
| pin_o | output | 1 | Output pin value |
| latch_rd_o | output | 8 | Latch readback, upper seven bits zero |

## Verification
A latch write is due one rising edge after the strobe, on both the readback and the pin. A carrier phase change is due on the rising edge that samples a tick. The bench drives inputs at the falling edge and advances its own tick-phase model at each rising edge. It then compares the pin and the readback at the next falling edge, so every result is checked in the cycle it becomes due. Stalled and irregular tick patterns show that nothing moves between ticks. Configuration changes happen only while the carrier is gated off, which matches how the inputs are meant to be used.

// File: rtl/irc_pkg.sv
package irc_pkg;
  typedef enum logic {
    IRC_LEVEL   = 1'b0,
    IRC_CARRIER = 1'b1
  } irc_mode_e;
endpackage

// File: rtl/irc_latch.sv
module irc_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              latch_o,
  output logic [DATA_W-1:0] rd_o
);
  logic latch_d, latch_q;

  always_comb begin
    latch_d = latch_q;
    if (wr_en_i) latch_d = wr_data_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= 1'b1;
    else         latch_q <= latch_d;
  end

  assign latch_o = latch_q;
  assign rd_o    = {{(DATA_W-1){1'b0}}, latch_q};

  // R12: a write lands at the sampling edge
  assert_write_lands_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> latch_o == $past(wr_data_i[0]));

  // R9: high data bits never reach the readback
  assert_upper_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_data_i[DATA_W-1:1] != '0)) |=> rd_o == {{(DATA_W-1){1'b0}}, $past(wr_data_i[0])});
endmodule

// File: rtl/irc_shaper.sv
module irc_shaper #(
  parameter int EXP_W = 2,
  parameter int PER_W = 5
) (
  input  logic             m3_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             third_i,
  output logic [PER_W-1:0] period_o,
  output logic [PER_W-1:0] high_o
);
  logic [PER_W-1:0] base;

  always_comb begin
    base     = m3_i ? PER_W'(3) : PER_W'(2);
    period_o = base << exp_i;
    if (!m3_i)            high_o = period_o >> 1;
    else if (exp_i == '0) high_o = PER_W'(1);
    else if (third_i)     high_o = PER_W'(1) << exp_i;
    else                  high_o = period_o >> 1;
  end
endmodule

// File: rtl/irc_divider.sv
module irc_divider #(
  parameter int PER_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [PER_W-1:0] high_i,
  output logic             wave_o
);
  logic [PER_W-1:0] cnt_d, cnt_q;
  logic             last;

  always_comb begin
    last  = (cnt_q >= period_i - PER_W'(1));
    cnt_d = cnt_q;
    if (!en_i)       cnt_d = '0;
    else if (tick_i) cnt_d = last ? '0 : cnt_q + PER_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign wave_o = en_i && (cnt_q < high_i);

  // R10: gate-on starts from phase zero
  assert_restart_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> cnt_q == '0);

  // R1: phase stays inside the configured period
  assert_phase_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q < period_i);

  // R1: the last phase wraps to zero on a tick
  assert_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && cnt_q == period_i - PER_W'(1)) |=> cnt_q == '0);

  // R11: no tick, no movement
  assert_hold_no_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$past(tick_i)) |-> cnt_q == $past(cnt_q));
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
  parameter int DATA_W = 8,
  parameter int EXP_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              carrier_mode_i,
  input  logic              ratio_m3_i,
  input  logic [EXP_W-1:0]  ratio_exp_i,
  input  logic              duty_third_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              pin_o,
  output logic [DATA_W-1:0] latch_rd_o
);
  import irc_pkg::*;

  localparam int MAX_RATIO = 3 * (2 ** ((2 ** EXP_W) - 1));
  localparam int PER_W     = $clog2(MAX_RATIO + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic             latch;
  logic             gate_on;
  logic             wave;
  logic [PER_W-1:0] period, high_cnt;
  irc_mode_e        mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign mode = irc_mode_e'(carrier_mode_i);

  irc_latch #(.DATA_W(DATA_W)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .latch_o  (latch),
    .rd_o     (latch_rd_o)
  );

  irc_shaper #(.EXP_W(EXP_W), .PER_W(PER_W)) u_shaper (
    .m3_i    (ratio_m3_i),
    .exp_i   (ratio_exp_i),
    .third_i (duty_third_i),
    .period_o(period),
    .high_o  (high_cnt)
  );

  assign gate_on = (mode == IRC_CARRIER) && !latch;

  irc_divider #(.PER_W(PER_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .en_i    (gate_on),
    .tick_i  (tick_i),
    .period_i(period),
    .high_i  (high_cnt),
    .wave_o  (wave)
  );

  assign pin_o = (mode == IRC_CARRIER) ? wave : latch;

  // R6: a closed gate in carrier mode keeps the pin low
  assert_gate_low_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (carrier_mode_i && latch_rd_o[0]) |-> !pin_o);

  // R7: level mode pin tracks the readback
  assert_level_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !carrier_mode_i |-> pin_o == latch_rd_o[0]);

  // R5: a gate-on edge shows the high phase first
  assert_start_high_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (carrier_mode_i && $past(carrier_mode_i) && $fell(latch_rd_o[0])) |-> pin_o);
endmodule

// File: tb/ir_carrier_gen_bench.sv
module ir_carrier_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       cmode;
  logic       m3;
  logic [1:0] nexp;
  logic       third;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       pin;
  logic [7:0] rd;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;
  bit rnd_tick = 0;
  int tick_div = 0;
  string tag   = "R8";

  bit m_lat;
  int m_phase;

  always #10 clk = ~clk;

  ir_carrier_gen u_ir_carrier_gen (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .carrier_mode_i(cmode),
    .ratio_m3_i(m3), .ratio_exp_i(nexp), .duty_third_i(third),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .pin_o(pin), .latch_rd_o(rd)
  );

  function automatic int exp_period();
    return (m3 ? 3 : 2) * (1 << nexp);
  endfunction

  function automatic int exp_high();
    int p = exp_period();
    if (p == 3)     return p / 3;   // R3
    if (!m3)        return p / 2;   // R2
    if (third)      return p / 3;   // R4
    return p / 2;                   // R4
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      if (n_fail < 30) $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic step();
    bit gate;
    if (rnd_tick) tick = ($urandom % 3) == 0;
    else          tick = (tick_div == 3);
    tick_div = (tick_div + 1) % 4;
    @(posedge clk);
    cycles++;
    gate = cmode && !m_lat;
    if (!rst_n) begin m_lat = 1; m_phase = 0; end
    else begin
      if (!gate) m_phase = 0;
      else if (tick) m_phase = (m_phase + 1) % exp_period();
      if (wr_en) m_lat = wr_data[0];
    end
    @(negedge clk);
    begin
      bit ep;
      ep = cmode ? (!m_lat && (m_phase < exp_high())) : m_lat;
      // R1/R5/R6/R7 waveform against tick-phase model
      check(pin == ep, {tag, " pin"}, pin, ep);
      // R9/R12 readback
      check(rd == {7'b0, m_lat}, {tag, " readback"}, rd, {7'b0, m_lat});
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic write_latch(logic [7:0] v);
    wr_en = 1; wr_data = v;
    step();
    wr_en = 0; wr_data = $urandom;
  endtask

  initial begin
    void'($urandom(32'd7741));
    rst_n = 0; tick = 0; cmode = 1; m3 = 0; nexp = 0; third = 0;
    wr_en = 0; wr_data = 0;
    m_lat = 1; m_phase = 0;
    @(negedge clk);
    run(3);
    rst_n = 1;
    run(3);
    // R8: reset state
    tag = "R8";
    check(rd == 8'h01, "R8 reset readback", rd, 1);
    check(pin == 1'b0, "R8 reset pin", pin, 0);

    // R7: level mode
    tag = "R7"; cmode = 0;
    run(2);
    write_latch(8'h00); run(5);
    check(pin == 1'b0, "R7 level low", pin, 0);
    write_latch(8'h01); run(5);
    check(pin == 1'b1, "R7 level high", pin, 1);

    // R9: upper bits ignored
    tag = "R9";
    write_latch(8'hFE);
    check(rd == 8'h00, "R9 write FE", rd, 0);
    write_latch(8'hA5);
    check(rd == 8'h01, "R9 write A5", rd, 1);

    // R3: ratio 3 coerced to one third
    tag = "R3"; cmode = 1; m3 = 1; nexp = 0; third = 0;
    run(2);
    write_latch(8'h00);
    check(pin == 1'b1, "R10 start high", pin, 1);
    run(60);
    write_latch(8'h01); run(3);

    // R4: ratio 24 both duties
    tag = "R4"; nexp = 3; third = 1;
    write_latch(8'h00); run(200);
    write_latch(8'h01); third = 0; run(2);
    write_latch(8'h00); run(200);
    write_latch(8'h01);

    // R2: m=2 all exponents
    tag = "R2"; m3 = 0;
    for (int k = 0; k < 4; k++) begin
      nexp = k[1:0]; run(2);
      write_latch(8'h00); run(140);
      write_latch(8'h01);
    end

    // R11: irregular ticks
    tag = "R11"; rnd_tick = 1; m3 = 1; nexp = 2; third = 1;
    write_latch(8'h00); run(300);
    write_latch(8'h01);
    rnd_tick = 0;

    // R10: cut mid-period, reopen
    tag = "R10"; m3 = 0; nexp = 3;
    write_latch(8'h00); run(21);
    write_latch(8'h01); run(2);
    write_latch(8'h00);
    check(pin == 1'b1, "R10 reopen high", pin, 1);
    run(70);
    write_latch(8'h01);

    // R1/R5/R6/R12 random configurations
    for (int s = 0; s < 40; s++) begin
      tag = "R1";
      cmode = ($urandom % 5) != 0;
      m3 = $urandom; nexp = $urandom; third = $urandom;
      rnd_tick = ($urandom % 4) == 0;
      run(1 + $urandom % 4);
      write_latch({$urandom, 1'b0} & 8'hFE);
      run(30 + $urandom % 150);
      write_latch(8'h01 | ($urandom & 8'hFE));
      tag = "R6";
      run(1 + $urandom % 6);
    end

    done = 1;
  end

  initial begin
    while (!done && cycles < 150000) @(negedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule